// File: doc/BRIEF.md
# Transfer Activation Enable Controller

This block keeps one enable bit per interrupt source that is allowed to start a data transfer engine. Forty-eight sources are arranged as six byte-wide enable registers that the CPU reads and writes one byte at a time. When a source raises an activation request, the block answers in the same cycle whether the request may start a transfer. That answer depends on the source's enable bit and on whether the index is in range.

A 16-bit block-transfer count register sits beside the enables. The CPU loads it with a word write, and each completion pulse from the transfer engine lowers it by one. A loaded value of zero stands for 65536 transfers.

The block clears enable bits by itself in two cases. The first is a completion whose "disable after this transfer" flag is set. The second is a completion whose decrement brings the count to zero. In both cases the bit cleared is the one belonging to the source that finished. A standby input and the reset both wipe all enables.

Top module: `xfer_act_enable`

## Requirements
- R1: After reset all six enable registers (addresses 0 to 5) read 0x00.
- R2: While `standby` is high, all enable bits are cleared at each clock edge, and an enable write in that cycle has no effect.
- R3: An enable write to address 0 to 5 stores `en_wdata` into that register at the next edge. `en_rdata` shows register `en_addr` combinationally. Addresses 6 and 7 read 0x00 and ignore writes.
- R4: `act_grant` is high in the same cycle exactly when `act_req` is high, `act_src` is below 48 and enable bit `act_src` is set. Bit `act_src` is bit `act_src[2:0]` of register `act_src[5:3]`.
- R5: A `xfer_done` pulse with `xfer_disel`=1 clears enable bit `xfer_src` at the next edge.
- R6: A `xfer_done` pulse whose decrement makes the count 0x0000 clears enable bit `xfer_src` at the next edge.
- R7: A `xfer_done` pulse with `xfer_disel`=0 and a decremented count other than zero leaves every enable bit unchanged.
- R8: Each `xfer_done` lowers the count by one, wrapping from 0x0000 to 0xFFFF. A `cnt_wr` loads `cnt_wdata`. When both occur in one cycle the load wins, there is no decrement, and no count-based clear happens.
- R9: After a load of 0x0000 the count-based clear happens on the 65536th completion and not before.
- R10: If a hardware clear and an enable write reach the same bit in one cycle, the bit ends at 0. The other bits of that byte take the written value.
- R11: A completion with `xfer_src` of 48 or more clears no enable bit, but it still decrements the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby | input | 1 | Hardware standby; clears all enables |
| en_wr | input | 1 | Enable register byte write strobe |
| en_addr | input | 3 | Enable register select (0 to 5 valid) |
| en_wdata | input | 8 | Enable write data |
| en_rdata | output | 8 | Enable read data for `en_addr` |
| cnt_wr | input | 1 | Count register word write strobe |
| cnt_wdata | input | 16 | Count write data (0 means 65536) |
| cnt_rdata | output | 16 | Current count value |
| act_req | input | 1 | Activation request |
| act_src | input | 6 | Requesting source index |
| act_grant | output | 1 | Request accepted |
| xfer_done | input | 1 | One transfer completed |
| xfer_src | input | 6 | Source of the completed transfer |
| xfer_disel | input | 1 | Disable source after this transfer |

## Verification
Two things can hit the same enable bit in one cycle: a CPU byte write and a hardware clear from a completion. A count load can also coincide with a decrement. Directed steps place a write of 0xFF to the register that holds `xfer_src` on the same edge as a disable-flagged completion, and a load on the same edge as a completion. The readback must show the written byte with only that source's bit at 0, and the count must equal the loaded value. The random phase then mixes writes, loads, completions and standby on every cycle. Each cycle's read data, count and grant are compared against a reference model in the bench that resolves these same-cycle cases by R8 and R10.

// File: rtl/xfer_act_enable.sv
module xfer_act_enable #(
  parameter int NUM_REGS = 6,
  parameter int AW       = 3,
  parameter int CW       = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          standby,
  input  logic          en_wr,
  input  logic [AW-1:0] en_addr,
  input  logic [7:0]    en_wdata,
  output logic [7:0]    en_rdata,
  input  logic          cnt_wr,
  input  logic [CW-1:0] cnt_wdata,
  output logic [CW-1:0] cnt_rdata,
  input  logic          act_req,
  input  logic [$clog2(NUM_REGS*8)-1:0] act_src,
  output logic          act_grant,
  input  logic          xfer_done,
  input  logic [$clog2(NUM_REGS*8)-1:0] xfer_src,
  input  logic          xfer_disel
);
  localparam int NB    = NUM_REGS * 8;
  localparam int SW    = $clog2(NB);
  localparam int PADW  = 8 * (2 ** AW);
  localparam logic [SW:0] NB_V = NB[SW:0];

  logic [NB-1:0]   en_q;
  logic [NB-1:0]   en_wrv;
  logic [NB-1:0]   clr_mask;
  logic [CW-1:0]   cnt_q;
  logic [PADW-1:0] en_pad;

  wire [CW-1:0] cnt_dec  = cnt_q - 1'b1;
  wire          dec_now  = xfer_done && !cnt_wr;
  wire          xsrc_ok  = {1'b0, xfer_src} < NB_V;
  wire          asrc_ok  = {1'b0, act_src} < NB_V;
  wire          hw_clear = xfer_done && xsrc_ok && (xfer_disel || (dec_now && cnt_dec == '0));

  assign clr_mask = hw_clear ? ({{(NB-1){1'b0}}, 1'b1} << xfer_src) : '0;

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_byte
    assign en_wrv[8*k +: 8] = (en_wr && en_addr == AW'(k)) ? en_wdata : en_q[8*k +: 8];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       en_q <= '0;
    else if (standby) en_q <= '0;
    else              en_q <= en_wrv & ~clr_mask;

  always_ff @(posedge clk)
    if (cnt_wr)         cnt_q <= cnt_wdata;
    else if (xfer_done) cnt_q <= cnt_dec;

  assign en_pad    = {{(PADW-NB){1'b0}}, en_q};
  assign en_rdata  = en_pad[{en_addr, 3'b000} +: 8];
  assign cnt_rdata = cnt_q;
  assign act_grant = act_req && asrc_ok && en_q[act_src];
endmodule

// File: rtl/xfer_act_enable_chk.sv
module xfer_act_enable_chk #(
  parameter int NB = 48,
  parameter int SW = 6,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          standby,
  input logic          en_wr,
  input logic          cnt_wr,
  input logic          act_req,
  input logic [SW-1:0] act_src,
  input logic          act_grant,
  input logic          xfer_done,
  input logic [SW-1:0] xfer_src,
  input logic          xfer_disel,
  input logic [CW-1:0] cnt_rdata,
  input logic [NB-1:0] en_bits
);
  localparam logic [SW:0] NB_V = NB[SW:0];

  AST_GRANT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    act_grant |-> (act_req && {1'b0, act_src} < NB_V)); // R4

  AST_STANDBY_WIPE: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> (en_bits == '0)); // R2

  AST_DISEL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && xfer_disel && {1'b0, xfer_src} < NB_V) |=> !en_bits[$past(xfer_src)]); // R5

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !cnt_wr) |=> (cnt_rdata == $past(cnt_rdata) - 1'b1)); // R8

  AST_HOLD_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !xfer_disel && cnt_rdata != 1 && !en_wr && !standby) |=> $stable(en_bits)); // R7
endmodule

bind xfer_act_enable xfer_act_enable_chk #(.NB(NB), .SW(SW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .standby(standby), .en_wr(en_wr), .cnt_wr(cnt_wr),
  .act_req(act_req), .act_src(act_src), .act_grant(act_grant),
  .xfer_done(xfer_done), .xfer_src(xfer_src), .xfer_disel(xfer_disel),
  .cnt_rdata(cnt_rdata), .en_bits(en_q)
);

// File: tb/tb_xfer_act_enable.sv
`timescale 1ns/1ps
module tb_xfer_act_enable;
  logic clk = 0, rst_n = 0, standby = 0;
  logic en_wr = 0, cnt_wr = 0, act_req = 0, xfer_done = 0, xfer_disel = 0;
  logic [2:0] en_addr = 0;
  logic [7:0] en_wdata = 0, en_rdata;
  logic [15:0] cnt_wdata = 0, cnt_rdata;
  logic [5:0] act_src = 0, xfer_src = 0;
  logic act_grant;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [47:0] en_m = 0;
  logic [15:0] cnt_m = 0;
  bit cnt_known = 0;

  always #2.5 clk = ~clk;

  xfer_act_enable dut (
    .clk(clk), .rst_n(rst_n), .standby(standby), .en_wr(en_wr), .en_addr(en_addr),
    .en_wdata(en_wdata), .en_rdata(en_rdata), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
    .cnt_rdata(cnt_rdata), .act_req(act_req), .act_src(act_src), .act_grant(act_grant),
    .xfer_done(xfer_done), .xfer_src(xfer_src), .xfer_disel(xfer_disel)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_rd(logic [2:0] a);
    return (a < 6) ? en_m[a*8 +: 8] : 8'h00;
  endfunction

  function automatic logic exp_grant();
    return act_req && act_src < 48 && en_m[act_src];
  endfunction

  task automatic model_edge();
    logic [15:0] d;
    logic [47:0] nxt;
    d = cnt_m - 16'd1;
    nxt = en_m;
    if (!rst_n || standby) nxt = '0;
    else begin
      if (en_wr && en_addr < 6) nxt[en_addr*8 +: 8] = en_wdata;
      if (xfer_done && xfer_src < 48 && (xfer_disel || (!cnt_wr && d == 16'd0)))
        nxt[xfer_src] = 1'b0;
    end
    en_m = nxt;
    if (cnt_wr) begin cnt_m = cnt_wdata; cnt_known = 1; end
    else if (xfer_done) cnt_m = d;
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic idle();
    en_wr = 0; cnt_wr = 0; act_req = 0; xfer_done = 0; xfer_disel = 0; standby = 0;
  endtask

  task automatic read_chk(logic [2:0] a, string req);
    en_wr = 0; en_addr = a; #1;
    check(req, en_rdata, exp_rd(a));
  endtask

  task automatic wr_en(logic [2:0] a, logic [7:0] v);
    en_wr = 1; en_addr = a; en_wdata = v; step(); en_wr = 0;
  endtask

  task automatic ld_cnt(logic [15:0] v);
    cnt_wr = 1; cnt_wdata = v; step(); cnt_wr = 0;
  endtask

  task automatic done_pulse(logic [5:0] s, logic dis);
    xfer_done = 1; xfer_src = s; xfer_disel = dis; step();
    xfer_done = 0; xfer_disel = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int seed;
    seed = $urandom(32'h5EED);
    @(negedge clk); step(); rst_n = 1; @(negedge clk);
    for (int a = 0; a < 6; a++) read_chk(3'(a), "R1 reset value");

    // R3 write/readback and unused addresses
    wr_en(3'd0, 8'hA5); read_chk(3'd0, "R3 write readback");
    wr_en(3'd5, 8'h3C); read_chk(3'd5, "R3 write readback reg5");
    wr_en(3'd6, 8'hFF); read_chk(3'd6, "R3 addr6 reads zero");
    read_chk(3'd7, "R3 addr7 reads zero");
    for (int a = 0; a < 6; a++) read_chk(3'(a), "R3 unused write ignored");

    // R4 grant
    act_req = 1; act_src = 6'd0; #1; check("R4 grant set bit", act_grant, 1);
    act_src = 6'd1; #1; check("R4 grant clear bit", act_grant, 0);
    act_src = 6'd42; #1; check("R4 grant reg5 bit2", act_grant, 1);
    act_src = 6'd50; #1; check("R4 out of range rejected", act_grant, 0);
    act_req = 0; act_src = 6'd0; #1; check("R4 no request", act_grant, 0);

    // R5 disable-after clear
    ld_cnt(16'd100);
    done_pulse(6'd2, 1); read_chk(3'd0, "R5 disel clears bit");
    check("R8 count decremented", cnt_rdata, 16'd99);

    // R7 hold
    done_pulse(6'd0, 0); read_chk(3'd0, "R7 hold on done");
    check("R8 count decremented again", cnt_rdata, 16'd98);

    // R6 count-out clear
    wr_en(3'd1, 8'hFF); ld_cnt(16'd2);
    done_pulse(6'd9, 0); read_chk(3'd1, "R6 not yet");
    done_pulse(6'd9, 0); read_chk(3'd1, "R6 count-out clears bit");
    check("R6 count at zero", cnt_rdata, 16'd0);
    done_pulse(6'd10, 0); check("R8 wrap to FFFF", cnt_rdata, 16'hFFFF);
    read_chk(3'd1, "R7 hold after wrap");

    // R10 write vs clear collision
    en_wr = 1; en_addr = 3'd3; en_wdata = 8'hFF;
    xfer_done = 1; xfer_src = 6'd28; xfer_disel = 1; step(); idle();
    read_chk(3'd3, "R10 clear wins");
    check("R10 byte value", en_rdata, 8'hEF);

    // R8 load beats decrement, no count-out clear
    wr_en(3'd4, 8'h01); ld_cnt(16'd1);
    cnt_wr = 1; cnt_wdata = 16'd7; xfer_done = 1; xfer_src = 6'd32; step(); idle();
    check("R8 load wins", cnt_rdata, 16'd7);
    read_chk(3'd4, "R8 no clear on load cycle");

    // R11 out-of-range completion
    wr_en(3'd5, 8'hFF);
    done_pulse(6'd60, 1);
    for (int a = 0; a < 6; a++) read_chk(3'(a), "R11 no clear");
    check("R11 count decremented", cnt_rdata, 16'd6);

    // R2 standby
    standby = 1; en_wr = 1; en_addr = 3'd2; en_wdata = 8'h77; step(); idle();
    for (int a = 0; a < 6; a++) read_chk(3'(a), "R2 standby clears");

    // R9 zero load = 65536
    wr_en(3'd2, 8'hFF); ld_cnt(16'd0);
    xfer_done = 1; xfer_src = 6'd17; xfer_disel = 0;
    for (int i = 0; i < 65535; i++) step();
    idle(); en_addr = 3'd2; #1;
    check("R9 bit held after 65535", en_rdata, 8'hFF);
    check("R9 count at one", cnt_rdata, 16'd1);
    done_pulse(6'd17, 0); read_chk(3'd2, "R9 cleared on 65536th");
    check("R9 byte value", en_rdata, 8'hFD);
    check("R9 count zero", cnt_rdata, 16'd0);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      en_wr = ($urandom % 4) == 0; en_addr = 3'($urandom); en_wdata = 8'($urandom);
      cnt_wr = ($urandom % 16) == 0; cnt_wdata = 16'($urandom % 6);
      xfer_done = ($urandom % 2) == 0; xfer_src = 6'($urandom); xfer_disel = ($urandom % 4) == 0;
      standby = ($urandom % 64) == 0;
      act_req = ($urandom % 2) == 0; act_src = 6'($urandom);
      #1;
      check("R4 random grant", act_grant, exp_grant());
      check("R3 random read", en_rdata, exp_rd(en_addr));
      if (cnt_known) check("R8 random count", cnt_rdata, cnt_m);
      step();
    end
    idle();
    for (int a = 0; a < 8; a++) read_chk(3'(a), "R10 random final state");
    finish_run();
  end
endmodule